// File: doc/BRIEF.md
# Delta-Sigma Bitstream Decimator

This block turns the one-bit output of a delta-sigma modulator into signed 16-bit PCM words. A programmable integer divider derives a modulator clock-enable tick from the system clock. On every tick the block samples the modulator bit. The bit feeds a fourth-order cascaded integrator-comb (CIC) decimation filter, which produces one result for every R ticks. R is chosen from 64, 128, 192 or 384.

Each filter result is scaled to 16 bits according to the selected ratio. An optional extra gain is applied, the value is saturated, and it is offered on a valid/ready output stream toward a FIFO. The output register holds a word until the sink accepts it. A new result that completes while the previous word is still waiting is discarded; it does not overwrite the waiting word. The sink must therefore accept each word within one output sample period, which is at least 192 system cycles.

A divider or ratio change while the block is enabled restarts decimation. Dropping the enable returns the block to its idle state.

Top module: `dsm_cic_decim`

## Requirements
- R1: `mod_tick` pulses once every D system clock cycles, where D is `div_sel` (8-bit); the first tick comes D cycles after enabling or restarting.
- R2: A `div_sel` value of 0, 1 or 2 behaves exactly like 3.
- R3: `ratio_sel` codes 0, 1, 2 and 3 give R = 64, 128, 192 and 384; every other code gives R = 64. One filter result completes for each R modulator ticks.
- R4: At each tick, `mod_bit` = 1 enters the filter as +1 and 0 enters as -1. The result C is the exact output of four integrators followed by four comb stages with differential delay 1, decimated by R, starting from all-zero state.
- R5: The output word is floor(C*(2+G) / 2^(s+1)), where s = 9, 13, 16 or 20 for R = 64, 128, 192 or 384. It is saturated to the range -32768..32767 and never wraps.
- R6: `gain_sel` G (0..15) multiplies the scaled result by (1 + G/2); G = 0 leaves it unchanged.
- R7: While `pcm_valid` is high and `pcm_ready` is low, `pcm_valid` stays high and `pcm_data` stays stable. A result completing during that wait is dropped.
- R8: With `en` low, all filter, divider and phase state is cleared, `pcm_valid` is low one cycle later, and `mod_tick` stays low. Re-enabling starts from zero state.
- R9: A change of `div_sel` or `ratio_sel` while `en` is high suppresses the tick in that cycle and clears the filter and the counters. A word already in the output register is kept.
- R10: After reset, `pcm_valid` and `mod_tick` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Filter enable; low clears the block |
| div_sel | input | 8 | Modulator clock divider D |
| ratio_sel | input | 4 | Decimation ratio code |
| gain_sel | input | 4 | Extra gain code G |
| mod_bit | input | 1 | Delta-sigma bitstream, sampled at each tick |
| mod_tick | output | 1 | Modulator clock-enable pulse |
| pcm_data | output | 16 | Signed PCM word |
| pcm_valid | output | 1 | Output word valid |
| pcm_ready | input | 1 | Sink accepts the word |

## Verification
Constant all-ones and all-zeros streams drive the filter to full scale. For R = 64 this reaches both saturation rails; for R = 384 it reaches a known mid-range value, so the ratio-dependent shift is separated from the clamp. An alternating stream has zero mean and exercises the sign mapping and the transient of the comb stages. Random streams of random density, with random divider, ratio code (including unused codes) and gain, are compared word by word against an exact integer model, which exposes any error in stage arithmetic or wrap handling. Random short stalls on the sink side, one long stall, a mid-stream ratio change and an enable drop check the holding, dropping and restart rules.

// File: rtl/dsm_cic_pkg.sv
package dsm_cic_pkg;
  localparam int ORDER     = 4;
  localparam int MAX_RATIO = 384;
  localparam int ACC_W     = ORDER * $clog2(MAX_RATIO) + 1;
  localparam int PH_W      = $clog2(MAX_RATIO);
  localparam int OUT_W     = 16;
  localparam int DIV_W     = 8;
  localparam int SEL_W     = 4;
  localparam int GAIN_W    = 4;
  localparam int MIN_DIV   = 3;

  typedef logic signed [ACC_W-1:0] acc_t;

  // last phase index (R-1) for a ratio code
  function automatic logic [PH_W-1:0] ratio_last(input logic [SEL_W-1:0] sel);
    case (sel)
      4'd1:    return PH_W'(127);
      4'd2:    return PH_W'(191);
      4'd3:    return PH_W'(383);
      default: return PH_W'(63);
    endcase
  endfunction

  // right shift bringing full scale R^4 near 2^15
  function automatic logic [5:0] ratio_shift(input logic [SEL_W-1:0] sel);
    case (sel)
      4'd1:    return 6'd13;
      4'd2:    return 6'd16;
      4'd3:    return 6'd20;
      default: return 6'd9;
    endcase
  endfunction
endpackage

// File: rtl/dsm_clk_div.sv
module dsm_clk_div #(
  parameter int DIV_W   = dsm_cic_pkg::DIV_W,
  parameter int MIN_DIV = dsm_cic_pkg::MIN_DIV
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_DIV);

  logic [DIV_W-1:0] eff_div;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] top_cnt;

  assign eff_div = (div_val < MIN_V) ? MIN_V : div_val;
  assign top_cnt = eff_div - 1'b1;
  assign tick    = !clear && (cnt == top_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (clear)           cnt <= '0;
    else if (cnt >= top_cnt)  cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  // minimum divide of three: never two ticks back to back
  assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n || clear)
    cnt < eff_div);
endmodule

// File: rtl/dsm_cic_core.sv
module dsm_cic_core #(
  parameter int ORDER = dsm_cic_pkg::ORDER,
  parameter int SEL_W = dsm_cic_pkg::SEL_W,
  parameter int PH_W  = dsm_cic_pkg::PH_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                tick,
  input  logic                mod_bit,
  input  logic [SEL_W-1:0]    ratio_sel,
  output logic                res_valid,
  output dsm_cic_pkg::acc_t   res_acc
);
  import dsm_cic_pkg::*;

  acc_t integ [ORDER];
  acc_t dly   [ORDER];
  acc_t sum   [ORDER];
  acc_t cin   [ORDER];
  acc_t comb_res;
  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] last_ph;
  logic            dec;

  assign last_ph = ratio_last(ratio_sel);
  assign dec     = tick && (phase == last_ph);

  // integrator chain and comb chain, each evaluated within one tick
  always_comb begin
    acc_t run;
    run = mod_bit ? acc_t'(1) : '1;
    for (int k = 0; k < ORDER; k++) begin
      run    = integ[k] + run;
      sum[k] = run;
    end
    for (int k = 0; k < ORDER; k++) begin
      cin[k] = run;
      run    = run - dly[k];
    end
    comb_res = run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < ORDER; k++) begin
        integ[k] <= '0;
        dly[k]   <= '0;
      end
      phase     <= '0;
      res_valid <= 1'b0;
      res_acc   <= '0;
    end else if (clear) begin
      for (int k = 0; k < ORDER; k++) begin
        integ[k] <= '0;
        dly[k]   <= '0;
      end
      phase     <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= dec;
      if (tick) begin
        for (int k = 0; k < ORDER; k++) integ[k] <= sum[k];
        phase <= dec ? '0 : phase + 1'b1;
      end
      if (dec) begin
        for (int k = 0; k < ORDER; k++) dly[k] <= cin[k];
        res_acc <= comb_res;
      end
    end
  end

  assert_phase_range_R3: assert property (@(posedge clk) disable iff (!rst_n || clear)
    phase <= last_ph);
  assert_result_after_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(tick));
  assert_clear_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (phase == '0) && !res_valid);
endmodule

// File: rtl/dsm_pcm_out.sv
module dsm_pcm_out #(
  parameter int ACC_W  = dsm_cic_pkg::ACC_W,
  parameter int OUT_W  = dsm_cic_pkg::OUT_W,
  parameter int GAIN_W = dsm_cic_pkg::GAIN_W,
  parameter int SEL_W  = dsm_cic_pkg::SEL_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    in_valid,
  input  logic signed [ACC_W-1:0] in_acc,
  input  logic [SEL_W-1:0]        ratio_sel,
  input  logic [GAIN_W-1:0]       gain_sel,
  output logic signed [OUT_W-1:0] o_data,
  output logic                    o_valid,
  input  logic                    o_ready
);
  import dsm_cic_pkg::ratio_shift;

  localparam int PROD_W = ACC_W + GAIN_W + 2;
  localparam logic signed [PROD_W-1:0] MAX_V = PROD_W'((64'sd1 <<< (OUT_W-1)) - 1);
  localparam logic signed [PROD_W-1:0] MIN_V = -MAX_V - 1;

  logic [GAIN_W:0]          mult_u;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] shifted;
  logic [5:0]               shamt;
  logic signed [OUT_W-1:0]  sat_val;
  logic                     load;

  assign mult_u  = {1'b0, gain_sel} + (GAIN_W+1)'(2);
  assign prod    = PROD_W'(in_acc) * $signed(PROD_W'(mult_u));
  assign shamt   = ratio_shift(ratio_sel) + 6'd1;
  assign shifted = prod >>> shamt;

  always_comb begin
    if (shifted > MAX_V)      sat_val = MAX_V[OUT_W-1:0];
    else if (shifted < MIN_V) sat_val = MIN_V[OUT_W-1:0];
    else                      sat_val = shifted[OUT_W-1:0];
  end

  assign load = in_valid && (!o_valid || o_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_data  <= '0;
    end else if (clear) begin
      o_valid <= 1'b0;
    end else if (load) begin
      o_valid <= 1'b1;
      o_data  <= sat_val;
    end else if (o_ready) begin
      o_valid <= 1'b0;
    end
  end

  assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready && !clear) |=> (o_valid && $stable(o_data)));
  assert_clear_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !o_valid);
endmodule

// File: rtl/dsm_cic_decim.sv
module dsm_cic_decim #(
  parameter int DIV_W  = dsm_cic_pkg::DIV_W,
  parameter int SEL_W  = dsm_cic_pkg::SEL_W,
  parameter int GAIN_W = dsm_cic_pkg::GAIN_W,
  parameter int OUT_W  = dsm_cic_pkg::OUT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [DIV_W-1:0]        div_sel,
  input  logic [SEL_W-1:0]        ratio_sel,
  input  logic [GAIN_W-1:0]       gain_sel,
  input  logic                    mod_bit,
  output logic                    mod_tick,
  output logic signed [OUT_W-1:0] pcm_data,
  output logic                    pcm_valid,
  input  logic                    pcm_ready
);
  import dsm_cic_pkg::*;

  logic [DIV_W-1:0] div_q;
  logic [SEL_W-1:0] ratio_q;
  logic             cfg_chg;
  logic             clear;
  logic             res_valid;
  acc_t             res_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      ratio_q <= '0;
    end else begin
      div_q   <= div_sel;
      ratio_q <= ratio_sel;
    end
  end

  assign cfg_chg = en && ((div_sel != div_q) || (ratio_sel != ratio_q));
  assign clear   = !en || cfg_chg;

  dsm_clk_div #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .clear(clear), .div_val(div_sel), .tick(mod_tick)
  );

  dsm_cic_core #(.ORDER(ORDER), .SEL_W(SEL_W), .PH_W(PH_W)) u_core (
    .clk(clk), .rst_n(rst_n), .clear(clear), .tick(mod_tick), .mod_bit(mod_bit),
    .ratio_sel(ratio_sel), .res_valid(res_valid), .res_acc(res_acc)
  );

  dsm_pcm_out #(.ACC_W(ACC_W), .OUT_W(OUT_W), .GAIN_W(GAIN_W), .SEL_W(SEL_W)) u_out (
    .clk(clk), .rst_n(rst_n), .clear(!en), .in_valid(res_valid), .in_acc(res_acc),
    .ratio_sel(ratio_sel), .gain_sel(gain_sel), .o_data(pcm_data),
    .o_valid(pcm_valid), .o_ready(pcm_ready)
  );

  assert_restart_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |-> !mod_tick);
  assert_idle_no_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !mod_tick);
endmodule

// File: tb/dsm_cic_decim_bench.sv
module dsm_cic_decim_bench;
  localparam int LIMIT = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [7:0] div_sel = 8'd3;
  logic [3:0] ratio_sel = 4'd0;
  logic [3:0] gain_sel = 4'd0;
  logic mod_bit = 1'b0;
  logic mod_tick;
  logic signed [15:0] pcm_data;
  logic pcm_valid;
  logic pcm_ready = 1'b1;

  always #2 clk = ~clk;

  dsm_cic_decim u_dsm_cic_decim (
    .clk(clk), .rst_n(rst_n), .en(en), .div_sel(div_sel), .ratio_sel(ratio_sel),
    .gain_sel(gain_sel), .mod_bit(mod_bit), .mod_tick(mod_tick), .pcm_data(pcm_data),
    .pcm_valid(pcm_valid), .pcm_ready(pcm_ready)
  );

  int ntests = 0, nfail = 0;
  longint cyc = 0, last_tick = -1;
  logic nx_en = 0; logic [7:0] nx_div = 8'd3; logic [3:0] nx_ratio = 0, nx_gain = 0;
  logic [7:0] p_div = 8'd3; logic [3:0] p_ratio = 0;
  int pattern = 0, dens = 128, rdy_mode = 0, recv = 0;
  bit alt = 0, got_hs = 0;
  string cur_tag = "R4";
  longint mi [4], md [4];
  int mph = 0;
  logic signed [15:0] expq [$];

  task automatic chk(bit ok, string tag, longint act, longint exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rlen(logic [3:0] s);
    case (s) 4'd1: return 128; 4'd2: return 192; 4'd3: return 384; default: return 64; endcase
  endfunction
  function automatic int rsh(logic [3:0] s);
    case (s) 4'd1: return 13; 4'd2: return 16; 4'd3: return 20; default: return 9; endcase
  endfunction
  function automatic int effd(logic [7:0] d);
    return (d < 3) ? 3 : int'(d);
  endfunction

  function automatic logic signed [15:0] scale(longint c, logic [3:0] g, logic [3:0] s);
    longint p;
    p = (c * (2 + longint'(g))) >>> (rsh(s) + 1);
    if (p > 32767) return 16'sd32767;
    if (p < -32768) return -16'sd32768;
    return 16'(p);
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 4; k++) begin mi[k] = 0; md[k] = 0; end
    mph = 0; last_tick = -1;
  endtask

  task automatic model_push(bit b);
    longint run, t;
    run = b ? 1 : -1;
    for (int k = 0; k < 4; k++) begin run = mi[k] + run; mi[k] = run; end
    if (mph == rlen(nx_ratio) - 1) begin
      mph = 0;
      for (int k = 0; k < 4; k++) begin t = run; run = run - md[k]; md[k] = t; end
      expq.push_back(scale(run, nx_gain, nx_ratio));
    end else mph++;
  endtask

  task automatic step();
    bit chg, b;
    @(negedge clk);
    en = nx_en; div_sel = nx_div; ratio_sel = nx_ratio; gain_sel = nx_gain;
    case (rdy_mode)
      0: pcm_ready = 1'b1;
      1: pcm_ready = ($urandom % 4) != 0;
      default: pcm_ready = 1'b0;
    endcase
    case (pattern)
      0: b = 1'b1;
      1: b = 1'b0;
      2: begin alt = !alt; b = alt; end
      default: b = ($urandom % 256) < dens;
    endcase
    mod_bit = b;
    #1;
    chg = en && (div_sel != p_div || ratio_sel != p_ratio);
    p_div = div_sel; p_ratio = ratio_sel;
    if (!en) begin model_reset(); expq.delete(); end
    else if (chg) model_reset();
    else if (mod_tick) begin
      if (last_tick >= 0)
        chk(cyc - last_tick == effd(div_sel), (div_sel < 3) ? "R2 tick gap" : "R1 tick gap",
            cyc - last_tick, effd(div_sel));
      last_tick = cyc;
      model_push(b);
    end
    got_hs = 0;
    if (pcm_valid && pcm_ready) begin
      got_hs = 1; recv++;
      if (expq.size() == 0) chk(0, {cur_tag, " unexpected word"}, pcm_data, 0);
      else chk(pcm_data == expq[0], {cur_tag, " sample"}, pcm_data, expq[0]);
      if (expq.size() != 0) void'(expq.pop_front());
    end
    cyc++;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic run_cfg(int d, int r, int g, int pat, int dn, int nsamp, string tag);
    nx_en = 0; steps(2);
    nx_div = 8'(d); nx_ratio = 4'(r); nx_gain = 4'(g);
    pattern = pat; dens = dn; cur_tag = tag; recv = 0;
    steps(2);
    nx_en = 1;
    steps(nsamp * rlen(4'(r)) * effd(8'(d)) + 8);
    chk(recv >= nsamp - 1, {tag, " word count"}, recv, nsamp - 1);
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    nfail++;
    $display("FAIL R10 watchdog actual=%0d expected=<%0d", LIMIT, LIMIT);
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    steps(2);
    chk(pcm_valid == 1'b0, "R10 valid after reset", pcm_valid, 0);
    chk(mod_tick == 1'b0, "R10 tick after reset", mod_tick, 0);

    // divider: nominal and clamped values (R1, R2); value changes restart (R9)
    nx_en = 1; pattern = 3;
    nx_div = 8'd5;   steps(60);
    nx_div = 8'd0;   steps(40);
    nx_div = 8'd2;   steps(40);
    nx_div = 8'd1;   steps(40);
    nx_div = 8'd255; steps(800);

    // directed full-scale cases
    run_cfg(3, 0, 0, 0, 0, 6, "R5");      // +rail 32767
    chk(expq.size() <= 1, "R5 pending", expq.size(), 1);
    run_cfg(3, 0, 0, 1, 0, 6, "R5");      // -rail -32768
    run_cfg(3, 3, 0, 0, 0, 5, "R3");      // 20736 at R=384
    run_cfg(3, 2, 15, 0, 0, 5, "R6");     // gain drives into clamp
    run_cfg(4, 1, 3, 2, 0, 5, "R4");      // alternating stream
    run_cfg(3, 9, 2, 3, 200, 5, "R3");    // unused ratio code -> 64

    // random configurations with random stalls
    rdy_mode = 1;
    for (int i = 0; i < 7; i++) begin
      int r, g;
      r = $urandom % 16; if (i == 2) r = 3;
      g = ($urandom % 2) ? 0 : ($urandom % 16);
      run_cfg(3 + ($urandom % 2), r, g, 3, $urandom % 256, 4, (g != 0) ? "R6" : "R4");
    end
    rdy_mode = 0;

    // long stall: held word stable, later results dropped (R7)
    run_cfg(3, 0, 1, 3, 90, 3, "R7");
    rdy_mode = 2;
    while (!pcm_valid) step();
    begin
      logic signed [15:0] held; bit stable;
      held = pcm_data; stable = 1;
      chk(expq.size() > 0 && held == expq[0], "R7 held word", held, expq.size() ? expq[0] : 0);
      for (int i = 0; i < 600; i++) begin
        step();
        if (!pcm_valid || pcm_data != held) stable = 0;
      end
      chk(stable, "R7 stall stable", pcm_data, held);
      rdy_mode = 0; step();
      chk(got_hs, "R7 stall release", got_hs, 1);
      rdy_mode = 2; nx_en = 0; steps(2);
      chk(pcm_valid == 1'b0, "R8 valid cleared", pcm_valid, 0);
      chk(mod_tick == 1'b0, "R8 no tick while idle", mod_tick, 0);
      rdy_mode = 0;
    end

    // mid-stream ratio change (R9)
    run_cfg(4, 1, 0, 3, 160, 2, "R9");
    got_hs = 0;
    while (!got_hs) step();
    nx_ratio = 4'd2; cur_tag = "R9"; recv = 0;
    steps(5 * 192 * 4 + 8);
    chk(recv >= 4, "R9 words after restart", recv, 4);

    // disable then re-enable from zero state (R8)
    nx_en = 0; steps(3);
    chk(pcm_valid == 1'b0 && mod_tick == 1'b0, "R8 idle outputs", {pcm_valid, mod_tick}, 0);
    nx_en = 1; cur_tag = "R8"; recv = 0;
    steps(5 * 192 * 4 + 8);
    chk(recv >= 4, "R8 words after re-enable", recv, 4);

    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule